// File: doc/BRIEF.md
# Pin Controller with Event Latch

This block drives and observes 64 general-purpose pins from a simple register bus. Each bus request carries one 64-bit word, and registers sit on an 8-byte stride. Bit n of every register belongs to pin n. Software picks the direction of each pin and sets its output level. The output level can be written whole, or changed one bit at a time through set, clear and toggle addresses, so no read-modify-write is needed. Pin levels are brought into the clock domain by a two-flop synchronizer and can be read back.

Every pin has its own event detector. The detector can watch for a rising edge, a falling edge, a high level or a low level. Detected events collect in a sticky latch word, and software clears that word by writing ones. A mask word decides which latched pins may raise the single interrupt line. The mask never stops the latch from recording.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction, output, detector type, detector polarity and latch are all zero, the mask is all ones, and `irq` is low.
- R2: The direction word at byte offset 0x00 can be written and read back, and it drives `pin_oe` bit for bit (1 = output, 0 = input).
- R3: A write to offset 0x10 replaces the output word, which drives `pin_out`. A read of 0x10 returns zero because that address is write-only.
- R4: Offset 0x20 ORs the written word into the output word, 0x18 clears the bits written as 1, and 0x28 XORs the written word in. Bits written as 0 keep their value.
- R5: Offset 0x08 is read-only and returns `pin_in` after two synchronizing flops. Writes to it have no effect.
- R6: When the type bit at 0x38 is 1, the pin is edge-sensitive. Polarity bit 1 at 0x40 selects rising edges and 0 selects falling edges, and the opposite edge is ignored.
- R7: When the type bit is 0, the pin is level-sensitive (polarity 1 = high, 0 = low), and its latch bit is set again on every cycle that the level is present. If a set and a clear of the same bit fall in one cycle, the set wins.
- R8: The latch reads at 0x48. Writing 1 to a bit at 0x50 clears that latch bit, and bits written as 0 stay as they were.
- R9: The latch records events whatever the mask at 0x30 holds. A mask bit of 1 disables that pin's interrupt.
- R10: `irq` is high exactly when some latch bit is set and its mask bit is 0.
- R11: Read data and `bus_rvalid` appear one cycle after the request. A read of a write-only, misaligned or unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 64 | Read data |
| pin_in | input | 64 | Levels sampled from the pins |
| pin_out | output | 64 | Output levels toward the pins |
| pin_oe | output | 64 | Output enables toward the pins |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong alias update or a stuck direction bit is visible at `pin_out` or `pin_oe` straight after the write edge, so it is caught within a single cycle. A fault in the synchronizer or the detector shows up in the latch three cycles after a pin changes, and it can be seen through a latch read or through `irq`. Level-mode re-setting, the case where a set and a clear collide, and edges of the wrong polarity are each exercised by stimulus that gives a different latch word if the detector is wrong. Reads of unmapped addresses must return zero on the cycle after the request.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned NUM_SLOTS = 11;

  typedef enum logic [3:0] {
    RS_DIR    = 4'd0,
    RS_IN     = 4'd1,
    RS_OUT    = 4'd2,
    RS_CLR    = 4'd3,
    RS_SET    = 4'd4,
    RS_TGL    = 4'd5,
    RS_MASK   = 4'd6,
    RS_TYPE   = 4'd7,
    RS_POL    = 4'd8,
    RS_LAT    = 4'd9,
    RS_LATCLR = 4'd10,
    RS_NONE   = 4'd15
  } reg_sel_e;

  function automatic reg_sel_e slot_to_sel(input logic [3:0] idx);
    case (idx)
      4'd0:    return RS_DIR;
      4'd1:    return RS_IN;
      4'd2:    return RS_OUT;
      4'd3:    return RS_CLR;
      4'd4:    return RS_SET;
      4'd5:    return RS_TGL;
      4'd6:    return RS_MASK;
      4'd7:    return RS_TYPE;
      4'd8:    return RS_POL;
      4'd9:    return RS_LAT;
      4'd10:   return RS_LATCLR;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);

  logic [NPINS-1:0] stg [STAGES];
  logic [NPINS-1:0] prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [NPINS-1:0] stg_d;
    if (i == 0) begin : g_first
      assign stg_d = pin_in;
    end else begin : g_rest
      assign stg_d = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] typ_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] lat_o
);

  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] lat_q, lat_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic edg_hit, lvl_hit;
    assign edg_hit = pol_i[g] ? (cur_i[g] & ~prev_i[g]) : (~cur_i[g] & prev_i[g]);
    assign lvl_hit = pol_i[g] ? cur_i[g] : ~cur_i[g];
    assign evt[g]  = typ_i[g] ? edg_hit : lvl_hit;
  end

  // a set in the same cycle as a clear wins
  always_comb lat_d = (lat_q & ~clr_i) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  // every detected event is in the latch one cycle later, mask or not
  assert_lat_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((lat_q & $past(evt)) == $past(evt)));

  // without a clear strobe no latched bit falls
  assert_lat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NPINS-1:0]  lat_i,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  typ_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  clr_o
);

  localparam int unsigned SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic              hit;
  reg_sel_e          sel;
  logic              wr_en, rd_en;

  logic [NPINS-1:0] dir_q, dir_d, out_q, out_d, mask_q, mask_d;
  logic [NPINS-1:0] typ_q, typ_d, pol_q, pol_d;
  logic [NPINS-1:0] rdata_q, rdata_d;
  logic             rvalid_q;

  assign slot  = bus_addr[ADDR_W-1:3];
  assign hit   = (bus_addr[2:0] == 3'b000) && (slot < SLOT_W'(NUM_SLOTS));
  assign sel   = hit ? slot_to_sel(slot[3:0]) : RS_NONE;
  assign wr_en = bus_req && bus_we;
  assign rd_en = bus_req && !bus_we;

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    mask_d = mask_q;
    typ_d  = typ_q;
    pol_d  = pol_q;
    clr_o  = '0;
    if (wr_en) begin
      case (sel)
        RS_DIR:    dir_d  = bus_wdata;
        RS_OUT:    out_d  = bus_wdata;
        RS_CLR:    out_d  = out_q & ~bus_wdata;
        RS_SET:    out_d  = out_q | bus_wdata;
        RS_TGL:    out_d  = out_q ^ bus_wdata;
        RS_MASK:   mask_d = bus_wdata;
        RS_TYPE:   typ_d  = bus_wdata;
        RS_POL:    pol_d  = bus_wdata;
        RS_LATCLR: clr_o  = bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      case (sel)
        RS_DIR:  rdata_d = dir_q;
        RS_IN:   rdata_d = sync_i;
        RS_MASK: rdata_d = mask_q;
        RS_TYPE: rdata_d = typ_q;
        RS_POL:  rdata_d = pol_q;
        RS_LAT:  rdata_d = lat_i;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      mask_q   <= '1;
      typ_q    <= '0;
      pol_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      dir_q    <= dir_d;
      out_q    <= out_d;
      mask_q   <= mask_d;
      typ_q    <= typ_d;
      pol_q    <= pol_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rd_en;
    end
  end

  assign dir_o      = dir_q;
  assign out_o      = out_q;
  assign mask_o     = mask_q;
  assign typ_o      = typ_q;
  assign pol_o      = pol_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_CLR) |=> ((out_q & $past(bus_wdata)) == '0));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (bus_rvalid && bus_rdata == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NPINS       = 64,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] sync_v, prev_v, lat_v, mask_v, typ_v, pol_v, clr_v;

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  gpio_bus_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .sync_i(sync_v), .lat_i(lat_v),
    .dir_o(pin_oe), .out_o(pin_out), .mask_o(mask_v),
    .typ_o(typ_v), .pol_o(pol_v), .clr_o(clr_v)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(sync_v), .prev_i(prev_v),
    .typ_i(typ_v), .pol_i(pol_v), .clr_i(clr_v), .lat_o(lat_v)
  );

  assign irq = |(lat_v & ~mask_v);

  // with every pin masked the line stays quiet, whatever is latched
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_v) |-> !irq);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [63:0] bus_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [7:0] A_DIR = 8'h00, A_IN = 8'h08, A_OUT = 8'h10, A_CLR = 8'h18,
                         A_SET = 8'h20, A_TGL = 8'h28, A_MASK = 8'h30, A_TYPE = 8'h38,
                         A_POL = 8'h40, A_LAT = 8'h48, A_LATCLR = 8'h50;

  // kind: 0 = read data, 1 = pin_out, 2 = pin_oe, 3 = no check
  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [1:0]  kind;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, A_DIR,  64'hFFFF_0000_0000_FFFF, 2'd2, 64'hFFFF_0000_0000_FFFF, 4'd2},  // R2
    '{1'b0, A_DIR,  64'h0,                   2'd0, 64'hFFFF_0000_0000_FFFF, 4'd2},  // R2
    '{1'b1, A_OUT,  64'h0123_4567_89AB_CDEF, 2'd1, 64'h0123_4567_89AB_CDEF, 4'd3},  // R3
    '{1'b1, A_SET,  64'hF000_0000_0000_000F, 2'd1, 64'hF123_4567_89AB_CDEF, 4'd4},  // R4
    '{1'b1, A_CLR,  64'h0100_0000_0000_0001, 2'd1, 64'hF023_4567_89AB_CDEE, 4'd4},  // R4
    '{1'b1, A_TGL,  64'hFFFF_FFFF_0000_0000, 2'd1, 64'h0FDC_BA98_89AB_CDEE, 4'd4},  // R4
    '{1'b0, A_OUT,  64'h0,                   2'd0, 64'h0,                   4'd3},  // R3
    '{1'b0, A_CLR,  64'h0,                   2'd0, 64'h0,                   4'd11}, // R11
    '{1'b1, A_MASK, 64'h00FF_00FF_00FF_00FF, 2'd3, 64'h0,                   4'd9},
    '{1'b0, A_MASK, 64'h0,                   2'd0, 64'h00FF_00FF_00FF_00FF, 4'd9},  // R9
    '{1'b1, A_TYPE, 64'h1234_5678_9ABC_DEF0, 2'd3, 64'h0,                   4'd6},
    '{1'b0, A_TYPE, 64'h0,                   2'd0, 64'h1234_5678_9ABC_DEF0, 4'd6},  // R6
    '{1'b1, A_POL,  64'h0F0F_0F0F_0F0F_0F0F, 2'd3, 64'h0,                   4'd6},
    '{1'b0, A_POL,  64'h0,                   2'd0, 64'h0F0F_0F0F_0F0F_0F0F, 4'd6},  // R6
    '{1'b0, 8'h58,  64'h0,                   2'd0, 64'h0,                   4'd11}, // R11
    '{1'b0, 8'h09,  64'h0,                   2'd0, 64'h0,                   4'd11}, // R11
    '{1'b1, A_IN,   64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 64'h0FDC_BA98_89AB_CDEE, 4'd5},  // R5
    '{1'b0, A_IN,   64'h0,                   2'd0, 64'h0,                   4'd5}   // R5
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // tasks start at a negedge and return at the following negedge
  task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rvalid ? bus_rdata : 64'hDEAD_DEAD_DEAD_DEAD;
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] p;
    logic [63:0] exp_lat;
    repeat (3) @(negedge clk);
    // R1: reset values, latch read in the first cycle out of reset
    check("R1 irq", {63'b0, irq}, 64'h0);
    check("R1 pin_oe", pin_oe, 64'h0);
    check("R1 pin_out", pin_out, 64'h0);
    rst_n = 1'b1;
    bus_read(A_LAT, rd);  check("R1 latch", rd, 64'h0);
    bus_read(A_MASK, rd); check("R1 mask", rd, '1);
    bus_read(A_TYPE, rd); check("R1 type", rd, 64'h0);
    bus_read(A_POL, rd);  check("R1 polarity", rd, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) bus_write(TBL[i].addr, TBL[i].data);
      else           bus_read(TBL[i].addr, rd);
      case (TBL[i].kind)
        2'd0: check($sformatf("R%0d read", TBL[i].req), rd, TBL[i].exp);
        2'd1: check($sformatf("R%0d pin_out", TBL[i].req), pin_out, TBL[i].exp);
        2'd2: check($sformatf("R%0d pin_oe", TBL[i].req), pin_oe, TBL[i].exp);
        default: ;
      endcase
    end

    // rising-edge mode on every pin, everything masked, latch cleared (R8)
    bus_write(A_TYPE, '1);
    bus_write(A_POL, '1);
    bus_write(A_MASK, '1);
    bus_write(A_LATCLR, '1);
    bus_read(A_LAT, rd); check("R8 clear all", rd, 64'h0);

    p = 64'hA5A5_0000_0000_0021;
    pin_in = p;
    repeat (4) @(negedge clk);
    bus_read(A_IN, rd);  check("R5 input", rd, p);
    bus_read(A_LAT, rd); check("R6 rising latched", rd, p);
    check("R9 masked irq", {63'b0, irq}, 64'h0);

    bus_write(A_MASK, ~64'h20);
    check("R10 irq on unmask", {63'b0, irq}, 64'h1);
    bus_write(A_LATCLR, 64'h20);
    check("R10 irq after clear", {63'b0, irq}, 64'h0);
    exp_lat = p & ~64'h20;
    bus_read(A_LAT, rd); check("R8 single clear", rd, exp_lat);

    pin_in = '0;
    repeat (4) @(negedge clk);
    bus_read(A_LAT, rd); check("R6 falling ignored", rd, exp_lat);

    // falling-edge mode on pin 7
    bus_write(A_POL, ~64'h80);
    pin_in = 64'h80;
    repeat (4) @(negedge clk);
    bus_read(A_LAT, rd); check("R6 rise ignored in falling mode", rd, exp_lat);
    pin_in = '0;
    repeat (4) @(negedge clk);
    exp_lat = exp_lat | 64'h80;
    bus_read(A_LAT, rd); check("R6 falling latched", rd, exp_lat);

    // active-high level on pin 40
    bus_write(A_TYPE, ~(64'h1 << 40));
    bus_write(A_LATCLR, '1);
    bus_read(A_LAT, rd); check("R7 level idle", rd, 64'h0);
    pin_in = 64'h1 << 40;
    repeat (4) @(negedge clk);
    bus_write(A_LATCLR, 64'h1 << 40);
    bus_read(A_LAT, rd); check("R7 level re-sets over clear", rd, 64'h1 << 40);
    pin_in = '0;
    repeat (4) @(negedge clk);
    bus_write(A_LATCLR, 64'h1 << 40);
    bus_read(A_LAT, rd); check("R7 clear after level gone", rd, 64'h0);

    done = 1;
    report();
    $finish;
  end

endmodule